// File: doc/BRIEF.md
# Edge-Latched Interrupt Source Aggregator

This block collects up to six edge-triggered interrupt sources behind a single byte-wide register and drives one interrupt request line. The same register has two roles. A write at the register offset (0x1E on a 5-bit byte address) loads the per-source enable mask. A read at that offset returns the latched pending status of the sources.

A rising edge on an enabled source latches that source's pending bit. The bit stays set until software drops the source's enable bit, which clears it. Setting the enable again arms the source for its next edge. No write-one-to-clear mechanism exists, so software acknowledges an event by briefly dropping that source's enable.

A build-time mask marks which sources exist. A source outside the mask can never be enabled and always reads as 0. The interrupt request is a registered OR of the pending bits.

Top module: `intagg_ctrl`

## Requirements
- R1: After reset every enable bit and every pending bit is 0, the interrupt request is low, and a read returns 0.
- R2: A write with `wr_en_i` high and `addr_i` equal to 0x1E loads the enable mask from `wdata_i` bits 5:0, with bit n controlling source n. A write to any other address changes nothing.
- R3: While `addr_i` equals 0x1E, `rdata_o` bits 5:0 show the pending bits (bit n for source n), and bits 7:6 are 0. At any other address `rdata_o` is 0.
- R4: A rising edge on `src_i[n]` while source n is enabled sets pending bit n on that clock edge. The bit stays set after the source falls and while it stays low.
- R5: An edge on a disabled source is lost. A source that is already high when it becomes enabled does not set its bit until it falls and rises again.
- R6: Writing 0 to a source's enable bit clears its pending bit on that clock edge. Setting the enable again does not restore the old event: only a later rising edge sets the bit.
- R7: If a rising edge and a write that disables the same source arrive in one cycle, the pending bit ends up 0. If the write keeps the source enabled, the edge is latched.
- R8: A source outside the valid-source mask can never be enabled, and its pending bit always reads 0.
- R9: `irq_o` goes high one clock after any pending bit is set. It goes low one clock after all pending bits are 0.
- R10: Writing 0x00 to the register disables every source and clears every pending bit on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 5 | Byte address of the access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data (enable mask) |
| rdata_o | output | 8 | Read data (pending status), 0 when the address does not match |
| src_i | input | 6 | Interrupt source levels, edge detected internally |
| irq_o | output | 1 | Interrupt request, registered OR of pending bits |

## Verification
The assertions assume that `src_i`, `wr_en_i`, `addr_i` and `wdata_i` are synchronous to `clk_i` and stable around its rising edge. They also assume that a source is low at reset release, so that no edge is taken from the reset value of the edge detector. The bench keeps to this by changing every input on the falling edge and holding all sources low through reset. It uses a reduced valid-source mask (sources 0, 2, 3 and 5) so that invalid sources are exercised. It also sweeps every byte value of the enable write against a simultaneous rise of all sources.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
  localparam int unsigned INTAGG_ADDR_W  = 5;
  localparam int unsigned INTAGG_DATA_W  = 8;
  localparam int unsigned INTAGG_NUM_SRC = 6;
  localparam logic [INTAGG_ADDR_W-1:0] INTAGG_REG_OFS = 5'h1E;
endpackage

// File: rtl/intagg_rst_sync.sv
module intagg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/intagg_src_cell.sv
module intagg_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic wr_i,
  input  logic en_wr_i,
  output logic stat_o
);
  logic src_q, en_q, stat_q;
  logic rise, en_d, stat_d;

  always_comb begin
    rise   = src_i & ~src_q;
    en_d   = wr_i ? en_wr_i : en_q;
    // a disabling write wins over a same-cycle edge
    stat_d = en_d & (stat_q | (rise & en_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= 1'b0;
      en_q   <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      src_q  <= src_i;
      if (wr_i) en_q <= en_wr_i;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;

  assert_disable_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !en_wr_i) |=> !stat_o);

  assert_set_needs_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o) |-> $past(src_i && en_q && !src_q));

  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o && !wr_i) |=> stat_o);
endmodule

// File: rtl/intagg_irq_reg.sv
module intagg_irq_reg #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] stat_i,
  output logic         irq_o
);
  logic irq_q, irq_d;

  always_comb irq_d = |stat_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/intagg_ctrl.sv
module intagg_ctrl
  import intagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = INTAGG_NUM_SRC,
  parameter int unsigned DATA_W  = INTAGG_DATA_W,
  parameter int unsigned ADDR_W  = INTAGG_ADDR_W,
  parameter logic [ADDR_W-1:0]  REG_OFS    = INTAGG_REG_OFS,
  parameter logic [NUM_SRC-1:0] VALID_MASK = {NUM_SRC{1'b1}}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic              irq_o
);
  logic              rst_n;
  logic              sel, wr_hit;
  logic [NUM_SRC-1:0] stat;
  logic [DATA_W-1:0] rdata_d;
  logic              unused_in;

  intagg_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n)
  );

  always_comb begin
    sel    = (addr_i == REG_OFS);
    wr_hit = sel & wr_en_i;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (VALID_MASK[i]) begin : g_valid
      intagg_src_cell u_cell (
        .clk_i(clk_i), .rst_ni(rst_n), .src_i(src_i[i]),
        .wr_i(wr_hit), .en_wr_i(wdata_i[i]), .stat_o(stat[i])
      );
    end else begin : g_absent
      assign stat[i] = 1'b0;
    end
  end

  assign unused_in = ^{wdata_i, src_i};

  always_comb begin
    rdata_d = '0;
    if (sel) rdata_d[NUM_SRC-1:0] = stat;
  end
  assign rdata_o = rdata_d;

  intagg_irq_reg #(.N(NUM_SRC)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_n), .stat_i(stat), .irq_o(irq_o)
  );

  assert_irq_high_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|stat) |=> irq_o);

  assert_irq_low_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (stat == '0) |=> !irq_o);

  assert_zero_write_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_hit && wdata_i[NUM_SRC-1:0] == '0) |=> (stat == '0));

  assert_foreign_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !sel |-> (rdata_o == '0));
endmodule

// File: tb/tb_intagg_ctrl.sv
module tb_intagg_ctrl;
  localparam logic [4:0] REG   = 5'h1E;
  localparam logic [5:0] VALID = 6'b101101;

  logic       clk, rst_n, wr_en, irq;
  logic [4:0] addr;
  logic [7:0] wdata, rdata;
  logic [5:0] src;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  intagg_ctrl #(.VALID_MASK(VALID)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = REG;
  endtask

  task automatic set_src(input logic [5:0] v);
    @(negedge clk); src = v;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; addr = REG; wdata = 0; src = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    set_src(6'h3F);
    chk("R1 nothing enabled", rdata, 8'h00);
    set_src(6'h00);

    // R2/R3/R8: sweep every write byte against a rise on all sources
    for (int m = 0; m < 256; m++) begin
      wr(REG, 8'h00);
      set_src(6'h00);
      wr(REG, m[7:0]);
      set_src(6'h3F);
      chk("R2 R3 R8 sweep", rdata, {2'b00, m[5:0] & VALID});
      @(negedge clk);
      chk("R9 sweep irq", {7'b0, irq}, {7'b0, |(m[5:0] & VALID)});
    end
    set_src(6'h00);
    addr = 5'h1D;
    #1 chk("R3 other addr read", rdata, 8'h00);
    addr = REG;

    // R2: write elsewhere ignored
    wr(REG, 8'h00);
    wr(5'h1F, 8'h3F);
    wr(5'h0E, 8'h3F);
    set_src(6'h3F);
    chk("R2 foreign write", rdata, 8'h00);
    set_src(6'h00);

    // R4: sticky after source falls
    wr(REG, 8'h3F);
    set_src(6'h01);
    set_src(6'h00);
    repeat (3) @(negedge clk);
    chk("R4 sticky", rdata, 8'h01);
    set_src(6'h08);
    chk("R4 second source", rdata, 8'h09);

    // R5: disabled edge lost; already-high level not an edge
    wr(REG, 8'h00); set_src(6'h00);
    wr(REG, 8'h04);
    set_src(6'h01);
    chk("R5 disabled edge", rdata, 8'h00);
    set_src(6'h00);
    wr(REG, 8'h00);
    set_src(6'h04);
    wr(REG, 8'h04);
    repeat (2) @(negedge clk);
    chk("R5 level no edge", rdata, 8'h00);
    set_src(6'h00);
    set_src(6'h04);
    chk("R5 fresh edge", rdata, 8'h04);

    // R6: disable clears, re-enable re-arms only
    wr(REG, 8'h05);
    chk("R6 kept", rdata, 8'h00 | 8'h04);
    set_src(6'h00);
    wr(REG, 8'h01);
    chk("R6 disable clears", rdata, 8'h00);
    wr(REG, 8'h05);
    chk("R6 no memory", rdata, 8'h00);
    set_src(6'h04);
    chk("R6 rearmed", rdata, 8'h04);
    set_src(6'h00);

    // R7: same-cycle edge and disabling write
    wr(REG, 8'h00);
    wr(REG, 8'h01);
    @(negedge clk); src = 6'h01; wr_en = 1; wdata = 8'h00;
    @(negedge clk); wr_en = 0;
    chk("R7 write wins", rdata, 8'h00);
    set_src(6'h00);
    wr(REG, 8'h01);
    @(negedge clk); src = 6'h01; wr_en = 1; wdata = 8'h01;
    @(negedge clk); wr_en = 0;
    chk("R7 kept enabled latches", rdata, 8'h01);
    set_src(6'h00);

    // R9: irq timing
    wr(REG, 8'h00);
    wr(REG, 8'h08);
    repeat (2) @(negedge clk);
    chk("R9 idle", {7'b0, irq}, 8'h00);
    @(negedge clk); src = 6'h08;
    @(negedge clk);
    chk("R9 status first", rdata, 8'h08);
    chk("R9 irq lags", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R9 irq rises", {7'b0, irq}, 8'h01);
    wr(REG, 8'h00);
    chk("R9 cleared status", rdata, 8'h00);
    chk("R9 irq still high", {7'b0, irq}, 8'h01);
    @(negedge clk);
    chk("R9 irq falls", {7'b0, irq}, 8'h00);
    set_src(6'h00);

    // R10: zero write clears several pending
    wr(REG, 8'h2D);
    set_src(6'h2D);
    chk("R10 pending", rdata, 8'h2D);
    wr(REG, 8'h00);
    chk("R10 clears all", rdata, 8'h00);
    set_src(6'h00);
    set_src(6'h2D);
    chk("R10 all disabled", rdata, 8'h00);

    done = 1;
    finish_run();
  end
endmodule